// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This unit gathers single-cycle event pulses from the internal parts of a device into sticky status bits that the host can read. The host acknowledges an event by writing a one into its bit position. An enable register decides which status bits may raise the single host interrupt line. The line does not rise as soon as an enabled bit becomes pending. A programmable coalescing timer, counted in 32 µs units, holds it back so that several events can be served by one interrupt. An urgent receive event skips this wait.

A second status word collects flags from the DMA engine: one error flag, one urgent receive flag, two receive-channel flags and two transmit-channel flags. Three summary bits of the main status word show this word in folded form. The summary bits cannot be cleared in the main word; they fall when the host clears the DMA flags behind them. A periodic timer, set in its own byte of the configuration word, raises a receive-periodic status bit at a fixed interval.

The host reaches four 32-bit words through a simple register port with a 2-bit select, a write strobe and a read path that responds in the same cycle. Word 0 is the main status, word 1 is the enable mask, word 2 is the DMA status and word 3 is the configuration. A one-cycle `us_tick` strobe once per microsecond sets the time base.

Top module: `cic_top`

## Requirements
- R1: After reset the main status, enable and DMA status words read 0. The configuration word reads 0x00000040, which is a coalescing delay of 64 units with the periodic timer off. The interrupt line is low.
- R2: A pulse on `evt_main` sets the matching main status bit, but only for the implemented bits 0, 1, 3, 6, 7, 25, 26 and 28. The other bits read 0 unless they are summary bits. Writing 1 to word 0 clears a bit, and writing 0 leaves it as it is.
- R3: If a write-one-to-clear and a new event reach the same status bit in the same cycle, the bit stays set.
- R4: DMA word bits 31 (error), 30 (urgent receive), 17 and 16 (receive channels 1 and 0) and 1 and 0 (transmit channels 1 and 0) are sticky and cleared by writing ones. All other DMA bits read 0. Main bit 31 is the OR of DMA bits 30, 17 and 16, main bit 29 follows DMA bit 31, and main bit 27 is the OR of DMA bits 1 and 0. A write to word 0 does not clear these summary bits.
- R5: A pending status bit whose enable bit (word 1, same position) is 0 never raises `host_irq`.
- R6: With a coalescing delay D (configuration bits 7:0) that is not zero, an enabled event that arrives while nothing enabled is pending raises `host_irq` after D × 32 `us_tick` pulses plus one cycle. Once raised, the line stays high while any enabled bit is pending.
- R7: With a coalescing delay of 0, `host_irq` is high in the cycle after an enabled bit becomes pending.
- R8: If DMA bit 30 is set and enable bit 31 is set, `host_irq` is high at once, whatever the coalescing delay.
- R9: When the host clears all enabled pending bits, `host_irq` falls in the cycle after the write. The next enabled event waits the full delay again.
- R10: Configuration bits 15:8 set the periodic interval P. If P is not zero, main bit 28 is set every P × 32 `us_tick` pulses. If P is 0, the periodic timer is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 DMA status, 3 configuration |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected word, available in the same cycle |
| evt_main | input | 32 | Event pulses for the main status bits |
| evt_dma | input | 32 | Event pulses for the DMA status bits |
| host_irq | output | 1 | Host interrupt line |

## Verification
The case that needs care is a host clear and a hardware event landing on the same status bit in one cycle. The bench drives the event pulse and the write-one of that bit across the same clock edge, then reads the word back and expects the bit still set. A second overlap is the host clearing the last enabled bit while the coalescing timer is firing. The bench then sends a new event at once and checks that the line stays low for the full delay and rises only afterwards.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_ENABLE = 2'd1;
  localparam logic [1:0] SEL_DMA    = 2'd2;
  localparam logic [1:0] SEL_CONFIG = 2'd3;

  // main word: stored bits and summary positions
  localparam int unsigned MB_PERIODIC = 28;
  localparam int unsigned MB_SUM_RX   = 31;
  localparam int unsigned MB_SUM_ERR  = 29;
  localparam int unsigned MB_SUM_TX   = 27;
  localparam logic [WORD_W-1:0] MAIN_STORE_MASK = 32'h1600_00CB;

  // DMA word bit positions
  localparam int unsigned DB_ERR    = 31;
  localparam int unsigned DB_URGENT = 30;
  localparam int unsigned DB_RX1    = 17;
  localparam int unsigned DB_RX0    = 16;
  localparam int unsigned DB_TX1    = 1;
  localparam int unsigned DB_TX0    = 0;
  localparam logic [WORD_W-1:0] DMA_STORE_MASK = 32'hC003_0003;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_COUNT = 2'd1,
    CS_FIRE  = 2'd2
  } coal_state_e;
endpackage

// File: rtl/cic_unit_tick.sv
module cic_unit_tick #(
  parameter int unsigned UNIT_US = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic us_tick_i,
  output logic unit_o
);
  localparam int unsigned CW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (us_tick_i) begin
      cnt_en = 1'b1;
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign unit_o = run_i && us_tick_i && (cnt_q == LAST);
endmodule

// File: rtl/cic_w1c.sv
module cic_w1c #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         q_en;

  // a set in the same cycle as a clear wins
  always_comb begin
    q_d  = ((q_q & ~clr_i) | set_i) & MASK;
    q_en = (q_d != q_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cic_coalesce.sv
module cic_coalesce import cic_pkg::*; #(
  parameter int unsigned UNIT_US = 32,
  parameter int unsigned CFG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  logic [CFG_W-1:0] delay_i,
  input  logic             pending_i,
  output logic             fire_o
);
  coal_state_e      st_q, st_d;
  logic [CFG_W-1:0] uc_q, uc_d;
  logic [CFG_W:0]   uc_inc;
  logic             unit;
  logic             run;

  assign run    = (st_q == CS_COUNT);
  assign uc_inc = {1'b0, uc_q} + 1'b1;

  cic_unit_tick #(.UNIT_US(UNIT_US)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .us_tick_i (us_tick_i),
    .unit_o    (unit)
  );

  always_comb begin
    st_d = st_q;
    uc_d = uc_q;
    unique case (st_q)
      CS_IDLE: begin
        uc_d = '0;
        if (pending_i && (delay_i != '0)) st_d = CS_COUNT;
      end
      CS_COUNT: begin
        if (!pending_i) begin
          st_d = CS_IDLE;
          uc_d = '0;
        end else if (unit) begin
          if (uc_inc >= {1'b0, delay_i}) st_d = CS_FIRE;
          else                           uc_d = uc_inc[CFG_W-1:0];
        end
      end
      CS_FIRE: begin
        uc_d = '0;
        if (!pending_i) st_d = CS_IDLE;
      end
      default: begin
        st_d = CS_IDLE;
        uc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CS_IDLE;
      uc_q <= '0;
    end else begin
      st_q <= st_d;
      uc_q <= uc_d;
    end
  end

  assign fire_o = (st_q == CS_FIRE);
endmodule

// File: rtl/cic_period.sv
module cic_period #(
  parameter int unsigned UNIT_US = 32,
  parameter int unsigned CFG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  logic [CFG_W-1:0] period_i,
  output logic             hit_o
);
  logic [CFG_W-1:0] pc_q, pc_d;
  logic [CFG_W:0]   pc_inc;
  logic             run;
  logic             unit;

  assign run    = (period_i != '0);
  assign pc_inc = {1'b0, pc_q} + 1'b1;

  cic_unit_tick #(.UNIT_US(UNIT_US)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .us_tick_i (us_tick_i),
    .unit_o    (unit)
  );

  always_comb begin
    pc_d  = pc_q;
    hit_o = 1'b0;
    if (!run) begin
      pc_d = '0;
    end else if (unit) begin
      if (pc_inc >= {1'b0, period_i}) begin
        hit_o = 1'b1;
        pc_d  = '0;
      end else begin
        pc_d = pc_inc[CFG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/cic_top.sv
module cic_top import cic_pkg::*; #(
  parameter int unsigned     UNIT_US   = 32,
  parameter int unsigned     CFG_W     = 8,
  parameter logic [CFG_W-1:0] DELAY_RST = 'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic [1:0]  reg_sel,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [31:0] evt_main,
  input  logic [31:0] evt_dma,
  output logic        host_irq
);
  localparam int unsigned CFG_BITS = 2 * CFG_W;

  logic [WORD_W-1:0] main_q, dma_q, main_view, en_q, en_d;
  logic [WORD_W-1:0] main_set, main_clr, dma_clr;
  logic [CFG_W-1:0]  delay_q, delay_d, per_q, per_d;
  logic              en_we, cfg_we;
  logic              per_hit, fire, pending, urgent;

  // write decode
  assign en_we    = wr_en && (reg_sel == SEL_ENABLE);
  assign cfg_we   = wr_en && (reg_sel == SEL_CONFIG);
  assign main_clr = (wr_en && (reg_sel == SEL_STATUS)) ? wr_data : '0;
  assign dma_clr  = (wr_en && (reg_sel == SEL_DMA))    ? wr_data : '0;

  always_comb begin
    main_set = evt_main;
    main_set[MB_PERIODIC] = evt_main[MB_PERIODIC] | per_hit;
  end

  cic_w1c #(.W(WORD_W), .MASK(MAIN_STORE_MASK)) u_main (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (main_set),
    .clr_i (main_clr),
    .q_o   (main_q)
  );

  cic_w1c #(.W(WORD_W), .MASK(DMA_STORE_MASK)) u_dma (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_dma),
    .clr_i (dma_clr),
    .q_o   (dma_q)
  );

  // folded DMA summaries in the main view
  always_comb begin
    main_view = main_q;
    main_view[MB_SUM_RX]  = dma_q[DB_URGENT] | dma_q[DB_RX1] | dma_q[DB_RX0];
    main_view[MB_SUM_ERR] = dma_q[DB_ERR];
    main_view[MB_SUM_TX]  = dma_q[DB_TX1] | dma_q[DB_TX0];
  end

  // enable and configuration registers
  always_comb begin
    en_d    = en_q;
    delay_d = delay_q;
    per_d   = per_q;
    if (en_we) en_d = wr_data;
    if (cfg_we) begin
      delay_d = wr_data[CFG_W-1:0];
      per_d   = wr_data[CFG_BITS-1:CFG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= DELAY_RST;
      per_q   <= '0;
    end else if (cfg_we) begin
      delay_q <= delay_d;
      per_q   <= per_d;
    end
  end

  cic_period #(.UNIT_US(UNIT_US), .CFG_W(CFG_W)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick_i (us_tick),
    .period_i  (per_q),
    .hit_o     (per_hit)
  );

  assign pending = |(main_view & en_q);
  assign urgent  = dma_q[DB_URGENT] & en_q[MB_SUM_RX];

  cic_coalesce #(.UNIT_US(UNIT_US), .CFG_W(CFG_W)) u_coal (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick_i (us_tick),
    .delay_i   (delay_q),
    .pending_i (pending),
    .fire_o    (fire)
  );

  assign host_irq = pending && (fire || (delay_q == '0) || urgent);

  // read mux
  always_comb begin
    unique case (reg_sel)
      SEL_STATUS: rd_data = main_view;
      SEL_ENABLE: rd_data = en_q;
      SEL_DMA:    rd_data = dma_q;
      default:    rd_data = WORD_W'({per_q, delay_q});
    endcase
  end
endmodule

// File: rtl/cic_checker.sv
module cic_checker import cic_pkg::*; #(
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [31:0]      main_status,
  input logic [31:0]      enable,
  input logic [31:0]      dma_status,
  input logic [31:0]      evt_main,
  input logic [31:0]      evt_dma,
  input logic [CFG_W-1:0] delay,
  input logic             wr_en,
  input logic [1:0]       reg_sel,
  input logic [31:0]      wr_data
);
  localparam logic [31:0] KEEP_MASK = MAIN_STORE_MASK & ~(32'h1 << MB_PERIODIC);

  logic [31:0] evt_kept;
  logic        status_wr;
  assign evt_kept  = evt_main & MAIN_STORE_MASK;
  assign status_wr = wr_en && (reg_sel == SEL_STATUS) && (wr_data != '0);

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kept != '0) |=> ((main_status & $past(evt_kept)) == $past(evt_kept))); // R3

  AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_wr && ((evt_main & KEEP_MASK) == '0))
      |=> ((main_status & KEEP_MASK) == ($past(main_status) & KEEP_MASK))); // R2

  AST_DMA_ERR_FOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dma[DB_ERR] |=> main_status[MB_SUM_ERR]); // R4

  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((main_status & enable) != '0)); // R5

  AST_ZERO_DELAY_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((delay == '0) && ((main_status & enable) != '0)) |-> irq); // R7

  AST_URGENT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_status[DB_URGENT] && enable[MB_SUM_RX]) |-> irq); // R8
endmodule

bind cic_top cic_checker #(.CFG_W(CFG_W)) u_cic_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq         (host_irq),
  .main_status (main_view),
  .enable      (en_q),
  .dma_status  (dma_q),
  .evt_main    (evt_main),
  .evt_dma     (evt_dma),
  .delay       (delay_q),
  .wr_en       (wr_en),
  .reg_sel     (reg_sel),
  .wr_data     (wr_data)
);

// File: tb/cic_top_tb_top.sv
`timescale 1ns/1ps
module cic_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        us_tick;
  logic [1:0]  reg_sel;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [31:0] evt_main;
  logic [31:0] evt_dma;
  logic        host_irq;

  int n_checks;
  int n_fail;
  bit done;

  cic_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .reg_sel  (reg_sel),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .evt_main (evt_main),
    .evt_dma  (evt_dma),
    .host_irq (host_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = rd_data;
  endtask

  task automatic pulse_main(input logic [31:0] v);
    @(negedge clk); evt_main = v;
    @(negedge clk); evt_main = '0;
  endtask

  task automatic pulse_dma(input logic [31:0] v);
    @(negedge clk); evt_dma = v;
    @(negedge clk); evt_dma = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd1, d); chk("R1 enable", d, 32'h0);
    rd(2'd2, d); chk("R1 dma", d, 32'h0);
    rd(2'd3, d); chk("R1 config", d, 32'h0000_0040);
    chk("R1 irq", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse_main(32'h3);
    rd(2'd0, d); chk("R2 set", d, 32'h3);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R2 write zero keeps", d, 32'h3);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R2 clear bit0", d, 32'h2);
    pulse_main(32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 implemented bits", d, 32'h1600_00CB);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 clear all", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk);
    evt_main = 32'h40; reg_sel = 2'd0; wr_en = 1'b1; wr_data = 32'h40;
    @(negedge clk);
    evt_main = '0; wr_en = 1'b0; wr_data = '0;
    rd(2'd0, d); chk("R3 set beats clear", d, 32'h40);
    wr(2'd0, 32'h40);
    rd(2'd0, d); chk("R3 later clear", d, 32'h0);
  endtask

  task automatic t_dma;
    logic [31:0] d;
    pulse_dma(32'h0001_0000);
    rd(2'd2, d); chk("R4 dma rx0", d, 32'h0001_0000);
    rd(2'd0, d); chk("R4 rx summary", d, 32'h8000_0000);
    pulse_dma(32'h8000_0002);
    rd(2'd0, d); chk("R4 err and tx summary", d, 32'hA800_0000);
    pulse_dma(32'hFFFF_FFFF);
    rd(2'd2, d); chk("R4 dma implemented bits", d, 32'hC003_0003);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R4 summaries survive main write", d, 32'hA800_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R4 summaries fall", d, 32'h0);
  endtask

  task automatic t_enable_zero;
    wr(2'd3, 32'h0);
    pulse_main(32'h2);
    wait_cyc(3);
    chk("R5 disabled no irq", {31'b0, host_irq}, 32'h0);
    wr(2'd1, 32'h2);
    chk("R7 zero delay irq", {31'b0, host_irq}, 32'h1);
    wr(2'd0, 32'h2);
    chk("R9 irq falls on clear", {31'b0, host_irq}, 32'h0);
    wr(2'd1, 32'h1);
    pulse_main(32'h1);
    chk("R7 zero delay event", {31'b0, host_irq}, 32'h1);
    wr(2'd0, 32'h1);
  endtask

  task automatic t_delay_rearm;
    wr(2'd3, 32'h2);
    wr(2'd1, 32'h1);
    pulse_main(32'h1);
    wait_cyc(60);
    chk("R6 held back", {31'b0, host_irq}, 32'h0);
    wait_cyc(10);
    chk("R6 fired", {31'b0, host_irq}, 32'h1);
    wait_cyc(50);
    chk("R6 stays high", {31'b0, host_irq}, 32'h1);
    wr(2'd0, 32'h1);
    chk("R9 low after clear", {31'b0, host_irq}, 32'h0);
    pulse_main(32'h1);
    wait_cyc(60);
    chk("R9 full delay again", {31'b0, host_irq}, 32'h0);
    wait_cyc(10);
    chk("R9 fires again", {31'b0, host_irq}, 32'h1);
    wr(2'd0, 32'h1);
  endtask

  task automatic t_urgent;
    wr(2'd3, 32'hFF);
    wr(2'd1, 32'h8000_0000);
    pulse_dma(32'h4000_0000);
    chk("R8 urgent at once", {31'b0, host_irq}, 32'h1);
    wr(2'd2, 32'h4000_0000);
    chk("R8 cleared", {31'b0, host_irq}, 32'h0);
    pulse_dma(32'h0001_0000);
    wait_cyc(5);
    chk("R8 plain rx waits", {31'b0, host_irq}, 32'h0);
    wr(2'd2, 32'h0001_0000);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] d;
    wr(2'd3, 32'h0000_0140);
    rd(2'd3, d); chk("R10 config readback", d, 32'h0000_0140);
    wait_cyc(40);
    rd(2'd0, d); chk("R10 periodic set", d, 32'h1000_0000);
    wr(2'd3, 32'h0000_0040);
    wr(2'd0, 32'h1000_0000);
    wait_cyc(100);
    rd(2'd0, d); chk("R10 periodic off", d, 32'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; us_tick = 1'b1; reg_sel = '0; wr_en = 1'b0;
    wr_data = '0; evt_main = '0; evt_dma = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_w1c();
    t_collide();
    t_dma();
    t_enable_zero();
    t_delay_rearm();
    t_urgent();
    t_periodic();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule